// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a ring of transmit buffer descriptors held in system memory and turns the buffers they point to into frames on a byte stream. Software builds the descriptors, writes the ring base address, and then pokes a start register. The engine reads each descriptor in turn and copies its buffer into an internal frame store. It then writes the descriptor back with its ready flag cleared and moves on. Buffers are gathered across chained descriptors until one is marked as the last of its frame. That frame is then played out on a valid/ready byte stream. The walk stops at the first descriptor that is not ready, and the pointer stays on it so a later start resumes there.

Three events are reported: a buffer was consumed, a frame was completed, and a frame hit the size cap and was cut short (babble). They sit in a write-one-to-clear event register, and a mask selects which of them drive a level interrupt. Memory is reached through a single request/response port with one access in flight at a time.

Back-pressure: on the memory port a request stays valid with a stable address, direction and data until `mem_req_ready` is seen high at a clock edge. On the frame stream, `tx_valid`, `tx_data` and `tx_last` hold until `tx_ready` is high at a clock edge. The engine never drops a byte because the sink stalls.

Top module: `txbd_ring_engine`

## Requirements
- R1: A write to the start register (address 1) begins a ring walk only while `ctrl_enable` is high. With `ctrl_enable` low it makes no memory request, `busy` stays low and nothing changes.
- R2: A write to the ring base register (address 0) stores the data with bits 1:0 forced to zero. When the engine is idle, the same write also loads `cur_ptr`.
- R3: A descriptor has two 32-bit words. The word at the pointer holds flags in bits 15:0 (ready = bit 15, wrap = bit 13, last = bit 11) and the byte length in bits 31:16. The word at pointer+4 holds the buffer address, whose bits 1:0 are ignored. Buffer bytes are little-endian within words: the byte at address a sits in bits 8*(a mod 4)+7:8*(a mod 4).
- R4: The walk stops at the first descriptor whose ready bit is clear. `cur_ptr` then holds that descriptor's address and `busy` falls.
- R5: Every processed descriptor is written back at its own address with the ready bit cleared and all other flag bits and the length unchanged. Each writeback sets event bit 0 (buffer done).
- R6: A descriptor with the last bit ends the frame. The gathered bytes go out in order on the stream, with `tx_last` on the final byte. Event bit 1 (frame done) is set and the gather count restarts. If the gathered total is zero, no beat is sent but event bit 1 is still set.
- R7: When a buffer would take the gathered frame past MAX_FRAME bytes, only the remaining room is copied and event bit 2 (babble) is set.
- R8: After a descriptor with the wrap bit, the next descriptor is read at the ring base. Otherwise the next one is read at the current address plus 8.
- R9: A write to the event register (address 2) clears each bit written as 1 and keeps those written as 0. An event arriving in the same cycle wins over the clear.
- R10: `irq` is high exactly when some event bit is set and its bit in the mask register (address 3) is set.
- R11: A memory request is held stable until accepted, with at most one read outstanding. Each read gets one response on `mem_rsp_valid`, and writes get none.
- R12: While `tx_valid` is high and `tx_ready` low, `tx_valid`, `tx_data` and `tx_last` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_enable | input | 1 | Global enable; gates the start register |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 base, 1 start, 2 event clear, 3 mask |
| reg_wdata | input | 32 | Register write data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Word-aligned byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_rdata | input | 32 | Read response data |
| tx_valid | output | 1 | Frame byte valid |
| tx_ready | input | 1 | Sink accepts byte |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of frame |
| ev_flags | output | 3 | Event register: bit0 buffer done, bit1 frame done, bit2 babble |
| irq | output | 1 | Level interrupt |
| busy | output | 1 | Engine walking the ring |
| cur_ptr | output | ADDR_W | Current descriptor address |

## Verification
The in-design assertions check the following on every cycle:
- the memory request and the stream beat hold under stall;
- the gather count stays within the cap;
- the pointer steps by 8 or jumps to the base after each descriptor;
- a not-ready descriptor ends the walk;
- event bits obey the clear and set-wins rule.

Only the bench scenarios can show the rest:
- the content and boundaries of the gathered frames;
- the exact writeback words;
- babble truncation across a chained pair;
- an empty last descriptor;
- the disabled start;
- the interrupt masking.

Each scenario is compared with a ring walk modelled in the bench.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int BIT_READY = 15;
  localparam int BIT_WRAP  = 13;
  localparam int BIT_LAST  = 11;

  localparam logic [1:0] RA_BASE  = 2'd0;
  localparam logic [1:0] RA_START = 2'd1;
  localparam logic [1:0] RA_EVCLR = 2'd2;
  localparam logic [1:0] RA_MASK  = 2'd3;

  localparam int EV_BUF = 0;
  localparam int EV_FRM = 1;
  localparam int EV_BAB = 2;
  localparam int EV_W   = 3;

  typedef enum logic [3:0] {
    W_IDLE, W_D0_REQ, W_D0_RSP, W_D1_REQ, W_D1_RSP,
    W_CP_REQ, W_CP_RSP, W_WB, W_SEND, W_ADV
  } walk_state_t;
endpackage

// File: rtl/txr_regs.sv
module txr_regs
  import txr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_enable,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic [EV_W-1:0]   ev_set,
  output logic [ADDR_W-1:0] ring_base,
  output logic              base_wr,
  output logic              start,
  output logic [EV_W-1:0]   ev_flags,
  output logic              irq
);
  logic [EV_W-1:0] mask_q;
  logic [EV_W-1:0] clr;

  assign base_wr = reg_wr && (reg_addr == RA_BASE);
  assign start   = reg_wr && (reg_addr == RA_START) && ctrl_enable;
  assign clr     = (reg_wr && (reg_addr == RA_EVCLR)) ? reg_wdata[EV_W-1:0] : '0;
  assign irq     = |(ev_flags & mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring_base <= '0;
      mask_q    <= '0;
      ev_flags  <= '0;
    end else begin
      if (base_wr) ring_base <= {reg_wdata[ADDR_W-1:2], 2'b00};
      if (reg_wr && (reg_addr == RA_MASK)) mask_q <= reg_wdata[EV_W-1:0];
      ev_flags <= (ev_flags & ~clr) | ev_set;
    end
  end

  assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA_EVCLR && reg_wdata[EV_BUF] && !ev_set[EV_BUF]) |=> !ev_flags[EV_BUF]);
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_set[EV_FRM] |=> ev_flags[EV_FRM]);
endmodule

// File: rtl/txr_frame_store.sv
module txr_frame_store #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_base,
  input  logic [31:0]   wr_word,
  input  logic [2:0]    wr_cnt,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_byte
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int k = 0; k < 4; k++) begin
        if (k < int'(wr_cnt)) mem[wr_base + AW'(k)] <= wr_word[8*k +: 8];
      end
    end
  end

  assign rd_byte = mem[rd_addr];
endmodule

// File: rtl/txr_walker.sv
module txr_walker
  import txr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_FRAME = 2048,
  localparam int LEN_W = $clog2(MAX_FRAME + 1),
  localparam int SAW   = $clog2(MAX_FRAME)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_wdata,
  input  logic [ADDR_W-1:0] ring_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_rdata,
  output logic              st_wr_en,
  output logic [SAW-1:0]    st_wr_base,
  output logic [2:0]        st_wr_cnt,
  output logic [SAW-1:0]    st_rd_addr,
  input  logic [7:0]        st_rd_byte,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic [EV_W-1:0]   ev_set,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_ptr
);
  walk_state_t       state;
  logic [ADDR_W-1:0] ptr, baddr_q;
  logic [15:0]       flags_q, blen_q;
  logic [LEN_W-1:0]  acc, remain, send_idx, room, rem_next;
  logic [2:0]        nbytes;
  logic              pend, over;

  assign room     = LEN_W'(MAX_FRAME) - acc;
  assign over     = 32'(blen_q) > 32'(room);
  assign rem_next = over ? room : LEN_W'(blen_q);
  assign nbytes   = (remain >= LEN_W'(4)) ? 3'd4 : remain[2:0];
  assign busy     = (state != W_IDLE);
  assign cur_ptr  = ptr;

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_addr  = ptr;
    mem_req_wdata = {blen_q, flags_q & ~(16'h1 << BIT_READY)};
    case (state)
      W_D0_REQ: mem_req_valid = 1'b1;
      W_D1_REQ: begin mem_req_valid = 1'b1; mem_req_addr = ptr + ADDR_W'(4); end
      W_CP_REQ: begin mem_req_valid = 1'b1; mem_req_addr = baddr_q; end
      W_WB:     begin mem_req_valid = 1'b1; mem_req_we = 1'b1; end
      default: ;
    endcase
  end

  assign st_wr_en   = (state == W_CP_RSP) && mem_rsp_valid;
  assign st_wr_base = acc[SAW-1:0];
  assign st_wr_cnt  = nbytes;
  assign st_rd_addr = send_idx[SAW-1:0];

  assign tx_valid = (state == W_SEND) && (acc != '0);
  assign tx_data  = st_rd_byte;
  assign tx_last  = (send_idx == acc - LEN_W'(1));

  always_comb begin
    ev_set         = '0;
    ev_set[EV_BUF] = (state == W_WB) && mem_req_ready;
    ev_set[EV_FRM] = (state == W_SEND) && ((acc == '0) || (tx_ready && tx_last));
    ev_set[EV_BAB] = (state == W_D1_RSP) && mem_rsp_valid && over;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= W_IDLE;
      ptr      <= '0;
      baddr_q  <= '0;
      flags_q  <= '0;
      blen_q   <= '0;
      acc      <= '0;
      remain   <= '0;
      send_idx <= '0;
      pend     <= 1'b0;
    end else begin
      if (start) pend <= 1'b1;
      case (state)
        W_IDLE: begin
          if (base_wr) ptr <= {base_wdata[ADDR_W-1:2], 2'b00};
          if (pend) begin
            pend  <= start;
            state <= W_D0_REQ;
          end
        end
        W_D0_REQ: if (mem_req_ready) state <= W_D0_RSP;
        W_D0_RSP: if (mem_rsp_valid) begin
          flags_q <= mem_rsp_rdata[15:0];
          blen_q  <= mem_rsp_rdata[31:16];
          state   <= mem_rsp_rdata[BIT_READY] ? W_D1_REQ : W_IDLE;
        end
        W_D1_REQ: if (mem_req_ready) state <= W_D1_RSP;
        W_D1_RSP: if (mem_rsp_valid) begin
          baddr_q <= {mem_rsp_rdata[ADDR_W-1:2], 2'b00};
          remain  <= rem_next;
          state   <= (rem_next == '0) ? W_WB : W_CP_REQ;
        end
        W_CP_REQ: if (mem_req_ready) state <= W_CP_RSP;
        W_CP_RSP: if (mem_rsp_valid) begin
          acc     <= acc + LEN_W'(nbytes);
          remain  <= remain - LEN_W'(nbytes);
          baddr_q <= baddr_q + ADDR_W'(4);
          state   <= (remain == LEN_W'(nbytes)) ? W_WB : W_CP_REQ;
        end
        W_WB: if (mem_req_ready) begin
          send_idx <= '0;
          state    <= flags_q[BIT_LAST] ? W_SEND : W_ADV;
        end
        W_SEND: begin
          if (acc == '0) state <= W_ADV;
          else if (tx_ready) begin
            if (tx_last) begin
              acc   <= '0;
              state <= W_ADV;
            end else send_idx <= send_idx + LEN_W'(1);
          end
        end
        W_ADV: begin
          ptr   <= flags_q[BIT_WRAP] ? ring_base : ptr + ADDR_W'(8);
          state <= W_D0_REQ;
        end
        default: state <= W_IDLE;
      endcase
    end
  end

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));
  assert_tx_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
  assert_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc <= LEN_W'(MAX_FRAME));
  assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == W_ADV && !flags_q[BIT_WRAP]) |=> (cur_ptr == $past(cur_ptr) + ADDR_W'(8)));
  assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == W_ADV && flags_q[BIT_WRAP]) |=> (cur_ptr == $past(ring_base)));
  assert_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == W_D0_RSP && mem_rsp_valid && !mem_rsp_rdata[BIT_READY]) |=>
      (!busy && $stable(cur_ptr)));
endmodule

// File: rtl/txbd_ring_engine.sv
module txbd_ring_engine
  import txr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_FRAME = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_enable,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic [EV_W-1:0]   ev_flags,
  output logic              irq,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_ptr
);
  localparam int SAW = $clog2(MAX_FRAME);

  logic [ADDR_W-1:0] ring_base;
  logic              base_wr, start;
  logic [EV_W-1:0]   ev_set;
  logic              st_wr_en;
  logic [SAW-1:0]    st_wr_base, st_rd_addr;
  logic [2:0]        st_wr_cnt;
  logic [7:0]        st_rd_byte;

  txr_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ctrl_enable(ctrl_enable),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .ev_set(ev_set), .ring_base(ring_base), .base_wr(base_wr),
    .start(start), .ev_flags(ev_flags), .irq(irq)
  );

  txr_walker #(.ADDR_W(ADDR_W), .MAX_FRAME(MAX_FRAME)) u_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .base_wr(base_wr),
    .base_wdata(reg_wdata[ADDR_W-1:0]), .ring_base(ring_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .st_wr_en(st_wr_en),
    .st_wr_base(st_wr_base), .st_wr_cnt(st_wr_cnt),
    .st_rd_addr(st_rd_addr), .st_rd_byte(st_rd_byte),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .ev_set(ev_set), .busy(busy), .cur_ptr(cur_ptr)
  );

  txr_frame_store #(.DEPTH(MAX_FRAME)) u_store (
    .clk(clk), .wr_en(st_wr_en), .wr_base(st_wr_base),
    .wr_word(mem_rsp_rdata), .wr_cnt(st_wr_cnt),
    .rd_addr(st_rd_addr), .rd_byte(st_rd_byte)
  );
endmodule

// File: tb/test_txbd_ring_engine.sv
module test_txbd_ring_engine;
  localparam int MAXF = 2048;
  localparam int BASE = 32'h1000;

  logic clk = 0, rst_n = 0, ctrl_enable = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic mem_req_valid, mem_req_we, mem_req_ready = 0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic mem_rsp_valid = 0;
  logic [31:0] mem_rsp_rdata = 0;
  logic tx_valid, tx_last, tx_ready = 0;
  logic [7:0] tx_data;
  logic [2:0] ev_flags;
  logic irq, busy;
  logic [31:0] cur_ptr;

  always #10 clk = ~clk;

  txbd_ring_engine #(.ADDR_W(32), .MAX_FRAME(MAXF)) i_txbd_ring_engine (
    .clk(clk), .rst_n(rst_n), .ctrl_enable(ctrl_enable),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .ev_flags(ev_flags), .irq(irq),
    .busy(busy), .cur_ptr(cur_ptr)
  );

  int tests = 0, fails = 0;
  logic [31:0] mem [16384];
  logic [7:0] cap [8192];
  int cap_len = 0, cap_nf = 0, req_cnt = 0;
  int cap_ends [64];
  logic busy_seen = 0;

  logic [7:0] exp_b [8192];
  int exp_len, exp_nf, exp_ptr;
  int exp_ends [64];
  logic [2:0] exp_ev;
  int dl [8];
  logic [15:0] df [8];
  logic proc [8];

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 13 + (a >> 7)) ^ 8'hA5);
  endfunction

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      req_cnt <= req_cnt + 1;
      if (mem_req_we) mem[mem_req_addr[15:2]] <= mem_req_wdata;
      else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= mem[mem_req_addr[15:2]];
      end
    end
    if (tx_valid && tx_ready) begin
      cap[cap_len] <= tx_data;
      cap_len <= cap_len + 1;
      if (tx_last) begin
        cap_ends[cap_nf] <= cap_len + 1;
        cap_nf <= cap_nf + 1;
      end
    end
    if (busy) busy_seen <= 1'b1;
    mem_req_ready <= ($urandom % 4) != 0;
    tx_ready <= ($urandom % 3) != 0;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cap_len = 0; cap_nf = 0;
    @(negedge clk);
  endtask

  function automatic int bufa(input int i);
    return 32'h4000 + i * 32'h1000;
  endfunction

  task automatic setup_ring(input int n);
    for (int i = 0; i < n; i++) begin
      mem[(BASE >> 2) + 2*i]     = {16'(dl[i]), df[i]};
      mem[(BASE >> 2) + 2*i + 1] = bufa(i) | (i % 4);
    end
    if (n < 8) mem[(BASE >> 2) + 2*n] = 32'h0;
  endtask

  task automatic model(input int n);
    int i, acc;
    logic rdy [9];
    for (int k = 0; k < 9; k++) rdy[k] = (k < n) && df[k][15];
    for (int k = 0; k < 8; k++) proc[k] = 0;
    i = 0; acc = 0; exp_len = 0; exp_nf = 0; exp_ev = 0;
    for (int step = 0; step < 20; step++) begin
      int room, cl;
      if (!rdy[i]) break;
      rdy[i] = 0; proc[i] = 1;
      room = MAXF - acc;
      cl = (dl[i] > room) ? room : dl[i];
      if (dl[i] > room) exp_ev[2] = 1;
      for (int k = 0; k < cl; k++) begin
        exp_b[exp_len] = pat(bufa(i) + k);
        exp_len++;
      end
      acc += cl;
      exp_ev[0] = 1;
      if (df[i][11]) begin
        exp_ev[1] = 1;
        if (acc > 0) begin exp_ends[exp_nf] = exp_len; exp_nf++; end
        acc = 0;
      end
      i = df[i][13] ? 0 : i + 1;
    end
    exp_ptr = BASE + 8 * i;
  endtask

  task automatic run_and_check(input int n, input string tag);
    int bad, t;
    setup_ring(n);
    model(n);
    wr_reg(2'd0, BASE);
    wr_reg(2'd1, 0);
    t = 0;
    while (!busy && t < 20) begin @(negedge clk); t++; end
    t = 0;
    while (busy && t < 60000) begin @(negedge clk); t++; end
    repeat (2) @(negedge clk);
    chk(cap_nf == exp_nf, {tag, " R6 frame count"}, cap_nf, exp_nf);
    chk(cap_len == exp_len, {tag, " R6 byte count"}, cap_len, exp_len);
    bad = 0;
    for (int k = 0; k < exp_len && k < cap_len; k++) if (cap[k] !== exp_b[k]) bad++;
    chk(bad == 0, {tag, " R3 R6 byte content"}, bad, 0);
    bad = 0;
    for (int k = 0; k < exp_nf && k < cap_nf; k++) if (cap_ends[k] != exp_ends[k]) bad++;
    chk(bad == 0, {tag, " R6 frame boundaries"}, bad, 0);
    chk(ev_flags == exp_ev, {tag, " R5 R7 events"}, ev_flags, exp_ev);
    chk(cur_ptr == exp_ptr, {tag, " R4 R8 stop pointer"}, cur_ptr, exp_ptr);
    bad = 0;
    for (int k = 0; k < n; k++)
      if (proc[k] && mem[(BASE >> 2) + 2*k] !== {16'(dl[k]), df[k] & 16'h7FFF}) bad++;
    chk(bad == 0, {tag, " R5 writeback"}, bad, 0);
  endtask

  initial begin
    #(20 * 190000);
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int s;
    s = $urandom(32'd1234);
    for (int w = 0; w < 16384; w++)
      mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
    @(negedge clk);
    do_reset();

    // reset state
    chk(ev_flags == 0, "R9 reset events", ev_flags, 0);
    chk(irq == 0, "R10 reset irq", irq, 0);
    chk(busy == 0, "R4 reset busy", busy, 0);
    chk(cur_ptr == 0, "R2 reset pointer", cur_ptr, 0);
    chk(tx_valid == 0, "R12 reset stream", tx_valid, 0);

    // R2 base alignment
    wr_reg(2'd0, 32'h1003);
    chk(cur_ptr == 32'h1000, "R2 base low bits dropped", cur_ptr, 32'h1000);

    // R1 start while disabled
    dl[0] = 8; df[0] = 16'h8800;
    setup_ring(1);
    wr_reg(2'd0, BASE);
    busy_seen = 0;
    s = req_cnt;
    wr_reg(2'd1, 0);
    repeat (20) @(negedge clk);
    chk(!busy_seen, "R1 no walk when disabled", busy_seen, 0);
    chk(req_cnt == s, "R1 no memory request", req_cnt - s, 0);
    chk(cap_len == 0 && ev_flags == 0, "R1 no output", cap_len, 0);

    ctrl_enable = 1;
    // single descriptor frame
    do_reset();
    dl[0] = 13; df[0] = 16'h8800;
    run_and_check(1, "single");

    // chained with wrap on last
    do_reset();
    dl[0] = 5; df[0] = 16'h8000; dl[1] = 22; df[1] = 16'h8000; dl[2] = 7; df[2] = 16'hA800;
    run_and_check(3, "wrap");

    // babble across two buffers
    do_reset();
    dl[0] = 1500; df[0] = 16'h8000; dl[1] = 1000; df[1] = 16'h8800;
    run_and_check(2, "babble R7");

    // R9/R10 using events left by the babble run (all three set)
    wr_reg(2'd2, 32'h2);
    chk(ev_flags == 3'b101, "R9 w1c clears selected bit", ev_flags, 3'b101);
    wr_reg(2'd3, 32'h2);
    chk(irq == 0, "R10 masked irq low", irq, 0);
    wr_reg(2'd3, 32'h4);
    chk(irq == 1, "R10 unmasked irq high", irq, 1);
    wr_reg(2'd2, 32'h7);
    chk(ev_flags == 0 && irq == 0, "R9 R10 clear all", ev_flags, 0);

    // zero-length last
    do_reset();
    dl[0] = 0; df[0] = 16'h8800;
    run_and_check(1, "empty R6");

    // first not ready
    do_reset();
    dl[0] = 9; df[0] = 16'h0800;
    run_and_check(1, "notready R4");

    // random rings
    for (int it = 0; it < 10; it++) begin
      int n;
      do_reset();
      n = 1 + ($urandom % 6);
      for (int i = 0; i < n; i++) begin
        dl[i] = $urandom % 61;
        df[i] = 16'h8000 | 16'($urandom % 256) | (($urandom % 2) ? 16'h0800 : 16'h0);
      end
      df[n-1] = df[n-1] | 16'h0800 | ((($urandom % 2) != 0) ? 16'h2000 : 16'h0);
      run_and_check(n, "random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule